// File: doc/BRIEF.md
# Nested Vector Element Loop Sequencer

This block turns one scalar instruction that has been marked parallel into an ordered stream of issue slots. An outer loop walks the element index from 0 up to the vector length minus one; for each element an inner loop walks the sub-element index across the group size. While the inner loop runs, the outer index holds still. Each slot carries source and destination element offsets, source and destination sub-element offsets, and a flag that tells the datapath to write zero instead of computing.

A single predicate bit, picked by the outer element index, governs the whole group of sub-elements for that element. The mask can be complemented on the way in, and a flag selects the hardwired zero register as the mask source, so that complementing it gives an all-ones mask. Masked groups are either skipped or written with zeros. An execute stub answers each computed slot with a result status. In fail-first mode a fault or a zero result ends the loop early and reports a shortened vector length. A fault that cannot be absorbed this way is reported as a trap request.

Top module: `elem_loop_seq`

## Requirements
- R1: After reset the block is idle: `issueValid`, `writeZero`, `done` and `trapReq` are all low.
- R2: Slots are issued in strictly ascending order: the element index rises from 0 to VL-1, and within each element the sub-index rises from 0 to SUBVL-1. `subvlCode` encodes SUBVL as code+1, so 0 means 1 and 3 means 4. Source and destination offsets are equal on every slot.
- R3: Bit k of the effective mask enables or disables every sub-slot of element k together.
- R4: When `predInv` is high the mask is complemented before use. When `predZeroSrc` is high the raw mask is taken as all zeros, so with `predInv` it becomes all ones.
- R5: With `zeroing` high, each sub-slot of a masked element is issued with `writeZero` high for one cycle and waits for no result.
- R6: With `zeroing` low, a masked element issues nothing and uses exactly one cycle in total.
- R7: An enabled slot is shown for one cycle and the block then waits until `resValid` arrives. No slot is issued while it waits.
- R8: With `failFirst` high, a fault or zero result on element k>0 ends the run: `done` rises the next cycle with `finalVl`=k, `trapReq` low, and no further slot is issued.
- R9: A fault with `failFirst` low on any element, or with `failFirst` high on element 0, ends the run with `trapReq` and `done` together and `finalVl` equal to the requested VL.
- R10: With `failFirst` high, a zero result on element 0 ends the run with `finalVl`=1 and no trap. With `failFirst` low, zero results have no effect.
- R11: A run that is not cut short raises `done` for exactly one cycle, in the cycle after its last slot, with `finalVl` equal to VL.
- R12: A requested VL of 0 is taken as 1, and a VL above MAX_VL is truncated to MAX_VL.
- R13: A `start` pulse that arrives while a run is in progress is ignored.
- R14: With VL=1 and SUBVL=1 exactly one slot is issued, with all offsets at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only when idle |
| vlIn | input | VL_W | Requested vector length |
| subvlCode | input | SUB_W | Group size minus one |
| predMask | input | MAX_VL | Raw predicate mask, one bit per element |
| predInv | input | 1 | Complement the mask before use |
| predZeroSrc | input | 1 | Mask source is the hardwired zero register |
| zeroing | input | 1 | Write zero to masked slots instead of skipping them |
| failFirst | input | 1 | Enable data-dependent early termination |
| resValid | input | 1 | Result status from execute is valid |
| resFault | input | 1 | Issued slot faulted |
| resZero | input | 1 | Issued slot produced zero (including negative zero) |
| issueValid | output | 1 | A slot is issued this cycle |
| srcOff | output | EL_W | Source element offset |
| dstOff | output | EL_W | Destination element offset |
| srcSubOff | output | SUB_W | Source sub-element offset |
| dstSubOff | output | SUB_W | Destination sub-element offset |
| writeZero | output | 1 | Issued slot writes zero |
| done | output | 1 | Run complete, one-cycle pulse |
| finalVl | output | VL_W | Vector length after the run |
| trapReq | output | 1 | Run ended in a trap; valid with done |

## Verification
The assertions assume that the execute side returns at most one result for each computed slot and only while the sequencer is waiting for it. They also assume that its fault and zero flags mean nothing outside `resValid`. The bench's execute stub follows this. It watches for a computed slot, raises `resValid` for exactly one cycle one clock later, and derives the fault and zero flags from the element offset that was issued. Control inputs change only at the falling edge, with `start` held for a single cycle. The one exception is the deliberate second pulse that tests R13, which arrives mid-run.

// File: rtl/els_pkg.sv
package els_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } elsState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic stepSub;
    logic stepGroup;
    logic truncate;
  } elsCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic curActive;
    logic lastSub;
    logic lastElem;
    logic elemZero;
  } elsStat_t;

endpackage

// File: rtl/els_dpath.sv
module els_dpath
  import els_pkg::*;
#(
  parameter int MAX_VL  = 8,
  parameter int MAX_SUB = 4,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int EL_W  = $clog2(MAX_VL),
  localparam int SUB_W = $clog2(MAX_SUB)
) (
  input  logic              clk,
  input  logic              rstN,
  input  elsCtl_t           ctl,
  input  logic [VL_W-1:0]   vlIn,
  input  logic [SUB_W-1:0]  subvlCode,
  input  logic [MAX_VL-1:0] predMask,
  input  logic              predInv,
  input  logic              predZeroSrc,
  output elsStat_t          stat,
  output logic [EL_W-1:0]   elemIdx,
  output logic [SUB_W-1:0]  subIdx,
  output logic [VL_W-1:0]   finalVl
);

  logic [VL_W-1:0]   vlReg;
  logic [SUB_W-1:0]  subMax;
  logic [MAX_VL-1:0] effMask;
  logic [VL_W-1:0]   vlClamped;
  logic [MAX_VL-1:0] rawMask;

  always_comb begin
    if (vlIn == '0)
      vlClamped = VL_W'(1);
    else if (vlIn > VL_W'(MAX_VL))
      vlClamped = VL_W'(MAX_VL);
    else
      vlClamped = vlIn;
    rawMask = predZeroSrc ? '0 : predMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vlReg   <= VL_W'(1);
      subMax  <= '0;
      effMask <= '0;
      elemIdx <= '0;
      subIdx  <= '0;
      finalVl <= VL_W'(1);
    end else if (ctl.load) begin
      vlReg   <= vlClamped;
      subMax  <= subvlCode;
      effMask <= rawMask ^ {MAX_VL{predInv}};
      elemIdx <= '0;
      subIdx  <= '0;
      finalVl <= vlClamped;
    end else begin
      if (ctl.stepGroup) begin
        elemIdx <= elemIdx + EL_W'(1);
        subIdx  <= '0;
      end else if (ctl.stepSub) begin
        subIdx <= subIdx + SUB_W'(1);
      end
      if (ctl.truncate)
        finalVl <= (elemIdx == '0) ? VL_W'(1) : VL_W'(elemIdx);
    end
  end

  always_comb begin
    stat.curActive = effMask[elemIdx];
    stat.lastSub   = (subIdx == subMax);
    stat.lastElem  = (VL_W'(elemIdx) == (vlReg - VL_W'(1)));
    stat.elemZero  = (elemIdx == '0);
  end

endmodule

// File: rtl/els_ctrl.sv
module els_ctrl
  import els_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     zeroing,
  input  logic     failFirst,
  input  logic     resValid,
  input  logic     resFault,
  input  logic     resZero,
  input  elsStat_t stat,
  output elsCtl_t  ctl,
  output logic     issueValid,
  output logic     writeZero,
  output logic     done,
  output logic     trapReq
);

  elsState_t state, stateNxt;
  logic zeroR, ffR, trapR, trapSet;

  always_comb begin
    ctl        = '0;
    stateNxt   = state;
    issueValid = 1'b0;
    writeZero  = 1'b0;
    trapSet    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          stateNxt = ST_RUN;
        end
      end
      ST_RUN: begin
        if (stat.curActive) begin
          issueValid = 1'b1;
          stateNxt   = ST_WAIT;
        end else if (zeroR) begin
          issueValid = 1'b1;
          writeZero  = 1'b1;
          if (!stat.lastSub)      ctl.stepSub   = 1'b1;
          else if (stat.lastElem) stateNxt      = ST_DONE;
          else                    ctl.stepGroup = 1'b1;
        end else begin
          if (stat.lastElem) stateNxt      = ST_DONE;
          else               ctl.stepGroup = 1'b1;
        end
      end
      ST_WAIT: begin
        if (resValid) begin
          if (resFault && !(ffR && !stat.elemZero)) begin
            trapSet  = 1'b1;
            stateNxt = ST_DONE;
          end else if (ffR && (resFault || resZero)) begin
            ctl.truncate = 1'b1;
            stateNxt     = ST_DONE;
          end else begin
            stateNxt = ST_RUN;
            if (!stat.lastSub)      ctl.stepSub   = 1'b1;
            else if (stat.lastElem) stateNxt      = ST_DONE;
            else                    ctl.stepGroup = 1'b1;
          end
        end
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      zeroR <= 1'b0;
      ffR   <= 1'b0;
      trapR <= 1'b0;
    end else begin
      state <= stateNxt;
      if (ctl.load) begin
        zeroR <= zeroing;
        ffR   <= failFirst;
        trapR <= 1'b0;
      end else if (trapSet) begin
        trapR <= 1'b1;
      end
    end
  end

  assign done    = (state == ST_DONE);
  assign trapReq = done & trapR;

endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
  import els_pkg::*;
#(
  parameter int MAX_VL  = 8,
  parameter int MAX_SUB = 4,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int EL_W  = $clog2(MAX_VL),
  localparam int SUB_W = $clog2(MAX_SUB)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VL_W-1:0]   vlIn,
  input  logic [SUB_W-1:0]  subvlCode,
  input  logic [MAX_VL-1:0] predMask,
  input  logic              predInv,
  input  logic              predZeroSrc,
  input  logic              zeroing,
  input  logic              failFirst,
  input  logic              resValid,
  input  logic              resFault,
  input  logic              resZero,
  output logic              issueValid,
  output logic [EL_W-1:0]   srcOff,
  output logic [EL_W-1:0]   dstOff,
  output logic [SUB_W-1:0]  srcSubOff,
  output logic [SUB_W-1:0]  dstSubOff,
  output logic              writeZero,
  output logic              done,
  output logic [VL_W-1:0]   finalVl,
  output logic              trapReq
);

  elsCtl_t          ctl;
  elsStat_t         stat;
  logic [EL_W-1:0]  elemIdx;
  logic [SUB_W-1:0] subIdx;

  els_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .zeroing(zeroing),
    .failFirst(failFirst), .resValid(resValid), .resFault(resFault),
    .resZero(resZero), .stat(stat), .ctl(ctl), .issueValid(issueValid),
    .writeZero(writeZero), .done(done), .trapReq(trapReq)
  );

  els_dpath #(.MAX_VL(MAX_VL), .MAX_SUB(MAX_SUB)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .vlIn(vlIn), .subvlCode(subvlCode),
    .predMask(predMask), .predInv(predInv), .predZeroSrc(predZeroSrc),
    .stat(stat), .elemIdx(elemIdx), .subIdx(subIdx), .finalVl(finalVl)
  );

  // single-predicate sequencing: source and destination advance together
  assign srcOff    = elemIdx;
  assign dstOff    = elemIdx;
  assign srcSubOff = subIdx;
  assign dstSubOff = subIdx;

endmodule

// File: rtl/els_chk.sv
module els_chk #(
  parameter int MAX_VL  = 8,
  parameter int MAX_SUB = 4,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int EL_W  = $clog2(MAX_VL),
  localparam int SUB_W = $clog2(MAX_SUB)
) (
  input logic             clk,
  input logic             rstN,
  input logic             issueValid,
  input logic             writeZero,
  input logic [EL_W-1:0]  srcOff,
  input logic [SUB_W-1:0] srcSubOff,
  input logic             done,
  input logic [VL_W-1:0]  finalVl,
  input logic             trapReq
);

  logic                  seenIssue;
  logic [EL_W+SUB_W-1:0] lastPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenIssue <= 1'b0;
      lastPos   <= '0;
    end else if (done) begin
      seenIssue <= 1'b0;
    end else if (issueValid) begin
      seenIssue <= 1'b1;
      lastPos   <= {srcOff, srcSubOff};
    end
  end

  // R2
  ascending_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && seenIssue |-> {srcOff, srcSubOff} > lastPos);

  // R5
  zero_needs_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeZero |-> issueValid);

  // R7
  wait_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !writeZero |=> !issueValid);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  no_issue_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !issueValid);

  // R9
  trap_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> done);

  // R12
  final_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (finalVl >= VL_W'(1)) && (finalVl <= VL_W'(MAX_VL)));

endmodule

bind elem_loop_seq els_chk #(.MAX_VL(MAX_VL), .MAX_SUB(MAX_SUB)) u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .writeZero(writeZero),
  .srcOff(srcOff), .srcSubOff(srcSubOff), .done(done), .finalVl(finalVl),
  .trapReq(trapReq)
);

// File: tb/tb_elem_loop_seq.sv
module tb_elem_loop_seq;

  localparam int MAX_VL = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [3:0] vlIn = 4'd1;
  logic [1:0] subvlCode = 2'd0;
  logic [7:0] predMask = 8'h00;
  logic       predInv = 1'b0, predZeroSrc = 1'b0, zeroing = 1'b0, failFirst = 1'b0;
  logic       resValid = 1'b0, resFault = 1'b0, resZero = 1'b0;
  logic       issueValid, writeZero, done, trapReq;
  logic [2:0] srcOff, dstOff;
  logic [1:0] srcSubOff, dstSubOff;
  logic [3:0] finalVl;

  int checks = 0;
  int errors = 0;
  int totalCyc = 0;

  always #5 clk = ~clk;

  elem_loop_seq #(.MAX_VL(MAX_VL), .MAX_SUB(4)) dut (
    .clk(clk), .rstN(rstN), .start(start), .vlIn(vlIn), .subvlCode(subvlCode),
    .predMask(predMask), .predInv(predInv), .predZeroSrc(predZeroSrc),
    .zeroing(zeroing), .failFirst(failFirst), .resValid(resValid),
    .resFault(resFault), .resZero(resZero), .issueValid(issueValid),
    .srcOff(srcOff), .dstOff(dstOff), .srcSubOff(srcSubOff),
    .dstSubOff(dstSubOff), .writeZero(writeZero), .done(done),
    .finalVl(finalVl), .trapReq(trapReq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected slot queues from the behavioural model
  int qE[$], qS[$], qW[$];
  int expFinal, expCyc;
  bit expTrap;

  task automatic buildModel(input int vl, input int sub, input logic [7:0] m,
                            input bit inv, input bit zsrc, input bit zer,
                            input bit ff, input int faultAt, input int zeroAt);
    logic [7:0] eff;
    int vlc;
    bit stop;
    eff = (zsrc ? 8'h00 : m) ^ {8{inv}};
    vlc = (vl < 1) ? 1 : (vl > MAX_VL) ? MAX_VL : vl;
    qE.delete(); qS.delete(); qW.delete();
    expFinal = vlc; expTrap = 0; expCyc = 1; stop = 0;
    for (int e = 0; e < vlc && !stop; e++) begin
      if (!eff[e]) begin
        if (zer) begin
          for (int s = 0; s < sub; s++) begin
            qE.push_back(e); qS.push_back(s); qW.push_back(1); expCyc++;
          end
        end else expCyc++;
      end else begin
        for (int s = 0; s < sub && !stop; s++) begin
          qE.push_back(e); qS.push_back(s); qW.push_back(0); expCyc += 2;
          if (e == faultAt) begin
            if (ff && e > 0) expFinal = e; else expTrap = 1;
            stop = 1;
          end else if (ff && e == zeroAt) begin
            expFinal = (e > 0) ? e : 1;
            stop = 1;
          end
        end
      end
    end
  endtask

  task automatic runOp(input string req, input int vl, input int subCode,
                       input logic [7:0] m, input bit inv, input bit zsrc,
                       input bit zer, input bit ff, input int faultAt,
                       input int zeroAt, input bit inject);
    int cyc;
    bit fin, pend, pf, pz;
    buildModel(vl, subCode + 1, m, inv, zsrc, zer, ff, faultAt, zeroAt);
    @(negedge clk);
    vlIn = 4'(vl); subvlCode = 2'(subCode); predMask = m; predInv = inv;
    predZeroSrc = zsrc; zeroing = zer; failFirst = ff; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; fin = 0; pend = 0; pf = 0; pz = 0;
    while (!fin && cyc < 500) begin
      cyc++;
      if (pend) begin
        resValid = 1'b1; resFault = pf; resZero = pz; pend = 0;
      end else begin
        resValid = 1'b0; resFault = 1'b0; resZero = 1'b0;
      end
      if (inject && cyc == 2) begin
        // R13: second start mid-run with different settings
        start = 1'b1; vlIn = 4'd2; predMask = 8'h00; zeroing = 1'b1;
      end else if (inject && cyc == 3) start = 1'b0;
      if (issueValid) begin
        if (qE.size() == 0) begin
          check(0, req, "unexpected issue at element", int'(srcOff), -1);
        end else begin
          check(int'(srcOff) == qE[0] && int'(dstOff) == qE[0], req,
                "element offset", int'(srcOff), qE[0]);
          check(int'(srcSubOff) == qS[0] && int'(dstSubOff) == qS[0], req,
                "sub offset", int'(srcSubOff), qS[0]);
          check(int'(writeZero) == qW[0], req, "writeZero", int'(writeZero), qW[0]);
          void'(qE.pop_front()); void'(qS.pop_front()); void'(qW.pop_front());
        end
        if (!writeZero) begin
          pend = 1;
          pf = (int'(srcOff) == faultAt);
          pz = (int'(srcOff) == zeroAt);
        end
      end
      if (done) begin
        fin = 1;
        check(cyc == expCyc, req, "done cycle", cyc, expCyc);
        check(int'(finalVl) == expFinal, req, "finalVl", int'(finalVl), expFinal);
        check(trapReq == expTrap, req, "trapReq", int'(trapReq), int'(expTrap));
        check(qE.size() == 0, req, "slots missing", qE.size(), 0);
      end
      @(negedge clk);
      // R11: done lasts one cycle
      if (fin) check(!done, "R11", "done held", int'(done), 0);
    end
    if (!fin) check(0, req, "run never finished", cyc, expCyc);
    resValid = 1'b0; resFault = 1'b0; resZero = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!issueValid && !done && !trapReq && !writeZero, "R1", "outputs in reset",
          int'({issueValid, done, trapReq, writeZero}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!issueValid && !done, "R1", "idle after reset", int'({issueValid, done}), 0);

    runOp("R14", 1, 0, 8'h01, 0, 0, 0, 0, -1, -1, 0);
    runOp("R2",  5, 2, 8'hFF, 0, 0, 0, 0, -1, -1, 0);
    runOp("R3",  6, 1, 8'h2D, 0, 0, 0, 0, -1, -1, 0);
    runOp("R4",  6, 1, 8'h2D, 1, 0, 0, 0, -1, -1, 0);
    runOp("R4",  4, 3, 8'h00, 1, 1, 0, 0, -1, -1, 0);
    runOp("R6",  5, 1, 8'hFF, 0, 1, 0, 0, -1, -1, 0);
    runOp("R5",  4, 1, 8'h05, 0, 0, 1, 0, -1, -1, 0);
    runOp("R7",  3, 3, 8'h06, 0, 0, 1, 0, -1, -1, 0);
    runOp("R8",  6, 1, 8'hFF, 0, 0, 0, 1,  3, -1, 0);
    runOp("R8",  6, 0, 8'h3C, 0, 0, 0, 1, -1,  3, 0);
    runOp("R9",  4, 1, 8'hFF, 0, 0, 0, 1,  0, -1, 0);
    runOp("R9",  5, 0, 8'hFF, 0, 0, 0, 0,  2, -1, 0);
    runOp("R10", 4, 2, 8'hFF, 0, 0, 0, 1, -1,  0, 0);
    runOp("R10", 4, 0, 8'hFF, 0, 0, 0, 0, -1,  1, 0);
    runOp("R12", 0, 0, 8'hFF, 0, 0, 0, 0, -1, -1, 0);
    runOp("R12", 15, 0, 8'hFF, 0, 0, 0, 0, -1, -1, 0);
    runOp("R13", 6, 1, 8'hFF, 0, 0, 0, 0, -1, -1, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    totalCyc++;
    if (totalCyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", totalCyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule